// File: doc/BRIEF.md
# Two-Stage Deadline Comparator

This block watches a timebase that is split into two cascaded halves, a high count and a low count, and raises one interrupt when the combined count reaches a programmed deadline of twice the half width. It never compares the full width at once. After each deadline write it first decides, from the high half alone, whether to wait on a coarse high-half compare or to go straight to a fine low-half compare. When the coarse compare hits, it hands over to the fine compare in the same cycle, with no further write needed.

The counter and any list of software timers lie outside the block. The consumer writes a deadline and waits for the level interrupt. It then clears the status flags with a strobe. It can cancel a wait with a disarm strobe and read back the deadline it last wrote at any time. A deadline that has already passed produces no interrupt. The block falls back to idle and the consumer is expected to notice the expiry itself.

Controller states: `ST_IDLE` (nothing armed), `ST_EVAL` (one cycle after a write, compares the upper deadline half with the high count), `ST_WAIT_HI` (coarse compare armed), `ST_WAIT_LO` (fine compare armed), `ST_FIRED` (match seen, interrupt held). Transitions: any state goes to `ST_EVAL` on a write, and any other state goes to `ST_IDLE` on disarm. `ST_EVAL` goes to `ST_WAIT_HI` (deadline high half ahead), `ST_WAIT_LO` (equal) or `ST_IDLE` (behind, already past). `ST_WAIT_HI` goes to `ST_WAIT_LO` on a high match, to `ST_FIRED` when both halves match in the same cycle, or to `ST_IDLE` if the high count jumps past. `ST_WAIT_LO` goes to `ST_FIRED` on a full match, or to `ST_IDLE` once the high count moves away from the deadline's high half. `ST_FIRED` goes to `ST_IDLE` on a flag clear.

Top module: `deadline_cmp2`

## Requirements
- R1: After reset, irq, hi_armed, lo_armed, hi_flag and lo_flag are 0, and dl_rdback is 0.
- R2: When the clock edge after a write sees the upper deadline half greater than cnt_hi, hi_armed is 1 and lo_armed is 0 after that edge.
- R3: When the clock edge after a write sees the upper deadline half equal to cnt_hi, lo_armed is 1 and hi_armed is 0 after that edge. This holds even if cnt_hi reached that value only after the write.
- R4: While hi_armed, an edge where cnt_hi equals the upper deadline half sets hi_flag and arms the low compare with no new write. If cnt_lo also equals the lower half on that edge, lo_flag and irq rise at once.
- R5: While lo_armed, an edge where cnt_hi equals the upper half and cnt_lo equals the lower half sets lo_flag and irq, and clears lo_armed.
- R6: A deadline already in the past never raises irq. This covers an upper half below cnt_hi at evaluation, and a lower half already passed so that cnt_hi moves on. In both cases the block returns to idle with both compares disarmed.
- R7: A disarm strobe clears hi_armed and lo_armed on the next edge and leaves hi_flag, lo_flag and irq unchanged.
- R8: dl_rdback equals the data of the most recent write and stays unchanged through all other activity.
- R9: irq is a level that stays 1 until a flag_clr strobe, which clears hi_flag, lo_flag and irq on the next edge.
- R10: A write clears hi_flag, lo_flag and irq on the next edge, cancelling any pending or signalled match, and the new deadline is evaluated on the edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_hi | input | HALF_W | High half of the timebase count |
| cnt_lo | input | HALF_W | Low half of the timebase count |
| dl_wr | input | 1 | Deadline write strobe |
| dl_data | input | 2*HALF_W | Deadline value; upper half compared with cnt_hi |
| disarm | input | 1 | Disable both compares |
| flag_clr | input | 1 | Clear both match flags and the interrupt |
| irq | output | 1 | Match interrupt, level |
| hi_armed | output | 1 | Coarse high-half compare enabled |
| lo_armed | output | 1 | Fine low-half compare enabled |
| hi_flag | output | 1 | High-half match seen |
| lo_flag | output | 1 | Full match seen |
| dl_rdback | output | 2*HALF_W | Last written deadline |

## Verification
The bench builds the block with HALF_W set to 8, so a deadline is 16 bits and each half has only 256 values. Because the bench drives both count halves directly, it can place the high count just below, at, or past a deadline's upper half within a cycle. That makes the late fallback between write and evaluation reachable, as well as the same-edge handover where both halves match together and a lower half that is passed before the high count moves on. Short held intervals show that the interrupt level persists and that disarm leaves the flags intact.

// File: rtl/dlc_pkg.sv
package dlc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_EVAL    = 3'd1,
        ST_WAIT_HI = 3'd2,
        ST_WAIT_LO = 3'd3,
        ST_FIRED   = 3'd4
    } dlc_state_e;

    // Position of a deadline half relative to the matching count half.
    typedef enum logic [1:0] {
        REL_BEHIND = 2'd0,
        REL_EQUAL  = 2'd1,
        REL_AHEAD  = 2'd2
    } dlc_rel_e;

endpackage

// File: rtl/dlc_half_cmp.sv
module dlc_half_cmp
    import dlc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] target,
    input  logic [W-1:0] count,
    output dlc_rel_e     rel
);

    always_comb begin
        if (target == count) begin
            rel = REL_EQUAL;
        end else if (target > count) begin
            rel = REL_AHEAD;
        end else begin
            rel = REL_BEHIND;
        end
    end

endmodule

// File: rtl/dlc_deadline_reg.sv
module dlc_deadline_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr) begin
            q <= d;
        end
    end

    // R8: the stored deadline changes only on a write, and then to the written value
    p_rdback_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(q));
    p_rdback_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (q == $past(d)));

endmodule

// File: rtl/dlc_ctrl.sv
module dlc_ctrl
    import dlc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     dl_wr,
    input  logic     disarm,
    input  logic     flag_clr,
    input  dlc_rel_e hi_rel,
    input  dlc_rel_e lo_rel,
    output logic     hi_armed,
    output logic     lo_armed,
    output logic     hi_flag,
    output logic     lo_flag,
    output logic     irq
);

    dlc_state_e state, state_nxt;
    logic       hi_set, lo_set;

    // Next-state and match-event decode
    always_comb begin
        state_nxt = state;
        hi_set    = 1'b0;
        lo_set    = 1'b0;
        if (dl_wr) begin
            state_nxt = ST_EVAL;
        end else if (disarm) begin
            state_nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    state_nxt = ST_IDLE;
                end
                ST_EVAL: begin
                    unique case (hi_rel)
                        REL_AHEAD:  state_nxt = ST_WAIT_HI;
                        REL_EQUAL:  state_nxt = ST_WAIT_LO;
                        default:    state_nxt = ST_IDLE;
                    endcase
                end
                ST_WAIT_HI: begin
                    if (hi_rel == REL_EQUAL) begin
                        hi_set = 1'b1;
                        if (lo_rel == REL_EQUAL) begin
                            lo_set    = 1'b1;
                            state_nxt = ST_FIRED;
                        end else begin
                            state_nxt = ST_WAIT_LO;
                        end
                    end else if (hi_rel == REL_BEHIND) begin
                        state_nxt = ST_IDLE;
                    end
                end
                ST_WAIT_LO: begin
                    if (hi_rel != REL_EQUAL) begin
                        state_nxt = ST_IDLE;
                    end else if (lo_rel == REL_EQUAL) begin
                        lo_set    = 1'b1;
                        state_nxt = ST_FIRED;
                    end
                end
                ST_FIRED: begin
                    if (flag_clr) begin
                        state_nxt = ST_IDLE;
                    end
                end
                default: begin
                    state_nxt = ST_IDLE;
                end
            endcase
        end
    end

    // State and status flag registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            hi_flag <= 1'b0;
            lo_flag <= 1'b0;
        end else begin
            state <= state_nxt;
            if (dl_wr) begin
                hi_flag <= 1'b0;
                lo_flag <= 1'b0;
            end else begin
                hi_flag <= (hi_flag & ~flag_clr) | hi_set;
                lo_flag <= (lo_flag & ~flag_clr) | lo_set;
            end
        end
    end

    // Outputs
    always_comb begin
        hi_armed = (state == ST_WAIT_HI);
        lo_armed = (state == ST_WAIT_LO);
        irq      = lo_flag;
    end

    p_wr_cancel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dl_wr |=> (state == ST_EVAL && !irq && !hi_flag));
    p_disarm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (disarm && !dl_wr) |=> (!hi_armed && !lo_armed));
    p_disarm_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (disarm && !dl_wr && !flag_clr && irq) |=> irq);
    p_handover_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_armed && hi_rel == REL_EQUAL && !dl_wr && !disarm) |=> (hi_flag && (lo_armed || irq)));
    p_fire_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_armed && hi_rel == REL_EQUAL && lo_rel == REL_EQUAL && !dl_wr && !disarm) |=> (irq && !lo_armed));
    p_past_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EVAL && hi_rel == REL_BEHIND && !dl_wr && !disarm) |=> (state == ST_IDLE && !irq));
    p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !flag_clr && !dl_wr) |=> irq);
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !dl_wr && state != ST_WAIT_HI && state != ST_WAIT_LO) |=> (!irq && !hi_flag));
    p_arm_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hi_armed, lo_armed, irq && (state == ST_FIRED)}));

endmodule

// File: rtl/deadline_cmp2.sv
module deadline_cmp2
    import dlc_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [HALF_W-1:0]     cnt_hi,
    input  logic [HALF_W-1:0]     cnt_lo,
    input  logic                  dl_wr,
    input  logic [2*HALF_W-1:0]   dl_data,
    input  logic                  disarm,
    input  logic                  flag_clr,
    output logic                  irq,
    output logic                  hi_armed,
    output logic                  lo_armed,
    output logic                  hi_flag,
    output logic                  lo_flag,
    output logic [2*HALF_W-1:0]   dl_rdback
);

    localparam int DL_W = 2 * HALF_W;

    logic [DL_W-1:0] deadline;
    dlc_rel_e        rel [2];
    logic [HALF_W-1:0] counts [2];

    assign counts[0] = cnt_lo;
    assign counts[1] = cnt_hi;

    dlc_deadline_reg #(.W(DL_W)) u_dl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (dl_wr),
        .d     (dl_data),
        .q     (deadline)
    );

    // Index 0 compares the low halves, index 1 the high halves
    for (genvar g = 0; g < 2; g++) begin : g_half
        dlc_half_cmp #(.W(HALF_W)) u_cmp (
            .target (deadline[g*HALF_W +: HALF_W]),
            .count  (counts[g]),
            .rel    (rel[g])
        );
    end

    dlc_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .dl_wr    (dl_wr),
        .disarm   (disarm),
        .flag_clr (flag_clr),
        .hi_rel   (rel[1]),
        .lo_rel   (rel[0]),
        .hi_armed (hi_armed),
        .lo_armed (lo_armed),
        .hi_flag  (hi_flag),
        .lo_flag  (lo_flag),
        .irq      (irq)
    );

    assign dl_rdback = deadline;

endmodule

// File: tb/deadline_cmp2_bench.sv
module deadline_cmp2_bench;

    localparam int HW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [HW-1:0] cnt_hi = '0;
    logic [HW-1:0] cnt_lo = '0;
    logic          dl_wr = 1'b0;
    logic [2*HW-1:0] dl_data = '0;
    logic          disarm = 1'b0;
    logic          flag_clr = 1'b0;
    logic          irq, hi_armed, lo_armed, hi_flag, lo_flag;
    logic [2*HW-1:0] dl_rdback;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    deadline_cmp2 #(.HALF_W(HW)) u_deadline_cmp2 (
        .clk(clk), .rst_n(rst_n), .cnt_hi(cnt_hi), .cnt_lo(cnt_lo),
        .dl_wr(dl_wr), .dl_data(dl_data), .disarm(disarm), .flag_clr(flag_clr),
        .irq(irq), .hi_armed(hi_armed), .lo_armed(lo_armed),
        .hi_flag(hi_flag), .lo_flag(lo_flag), .dl_rdback(dl_rdback)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Ends one negedge after the write edge: state is then evaluating
    task automatic write_dl(input logic [2*HW-1:0] d);
        dl_wr = 1'b1;
        dl_data = d;
        step();
        dl_wr = 1'b0;
    endtask

    task automatic pulse_clr();
        flag_clr = 1'b1;
        step();
        flag_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 irq", irq, 0);
        chk("R1 armed", {hi_armed, lo_armed}, 0);
        chk("R1 flags", {hi_flag, lo_flag}, 0);
        chk("R1 rdback", dl_rdback, 0);
    endtask

    task automatic t_coarse_then_fine();
        cnt_hi = 8'h03; cnt_lo = 8'h00;
        write_dl(16'h0510);
        chk("R8 rdback", dl_rdback, 16'h0510);
        step();
        chk("R2 hi_armed", hi_armed, 1);
        chk("R2 lo_armed", lo_armed, 0);
        cnt_hi = 8'h05; cnt_lo = 8'h00;
        step();
        chk("R4 hi_flag", hi_flag, 1);
        chk("R4 handover lo_armed", {hi_armed, lo_armed}, 2'b01);
        chk("R4 no irq yet", irq, 0);
        cnt_lo = 8'h10;
        step();
        chk("R5 irq", irq, 1);
        chk("R5 lo_flag", lo_flag, 1);
        chk("R5 lo disarmed", lo_armed, 0);
        cnt_lo = 8'h11;
        step(); step(); step();
        chk("R9 irq held", irq, 1);
        pulse_clr();
        chk("R9 cleared", {irq, hi_flag, lo_flag}, 0);
        chk("R8 rdback kept", dl_rdback, 16'h0510);
    endtask

    task automatic t_same_edge();
        cnt_hi = 8'h01; cnt_lo = 8'h80;
        write_dl(16'h0200);
        step();
        chk("R2 hi_armed", hi_armed, 1);
        cnt_hi = 8'h02; cnt_lo = 8'h00;
        step();
        chk("R4 same-edge irq", irq, 1);
        chk("R4 both flags", {hi_flag, lo_flag}, 2'b11);
        pulse_clr();
    endtask

    task automatic t_fine_direct();
        cnt_hi = 8'h07; cnt_lo = 8'h20;
        write_dl(16'h0730);
        step();
        chk("R3 lo_armed", {hi_armed, lo_armed}, 2'b01);
        cnt_lo = 8'h30;
        step();
        chk("R5 irq", irq, 1);
        disarm = 1'b1;
        step();
        disarm = 1'b0;
        chk("R7 flags kept", {irq, lo_flag}, 2'b11);
        pulse_clr();
        chk("R9 cleared", irq, 0);
    endtask

    task automatic t_late_fallback();
        cnt_hi = 8'h08; cnt_lo = 8'h00;
        write_dl(16'h0940);
        cnt_hi = 8'h09;
        step();
        chk("R3 fallback lo_armed", {hi_armed, lo_armed}, 2'b01);
        cnt_lo = 8'h40;
        step();
        chk("R5 fallback irq", irq, 1);
        pulse_clr();
    endtask

    task automatic t_past();
        cnt_hi = 8'h0A; cnt_lo = 8'h00;
        write_dl(16'h0900);
        step();
        chk("R6 hi past armed", {hi_armed, lo_armed}, 0);
        cnt_hi = 8'h09;
        step();
        chk("R6 hi past irq", irq, 0);
        cnt_hi = 8'h0B; cnt_lo = 8'h50;
        write_dl(16'h0B40);
        step();
        chk("R3 lo_armed", lo_armed, 1);
        cnt_lo = 8'h60;
        step();
        chk("R6 lo past irq", irq, 0);
        cnt_hi = 8'h0C; cnt_lo = 8'h40;
        step();
        chk("R6 lo past idle", {irq, hi_armed, lo_armed}, 0);
    endtask

    task automatic t_disarm();
        cnt_hi = 8'h01; cnt_lo = 8'h00;
        write_dl(16'h0305);
        step();
        chk("R2 hi_armed", hi_armed, 1);
        disarm = 1'b1;
        step();
        disarm = 1'b0;
        chk("R7 disarmed", {hi_armed, lo_armed}, 0);
        cnt_hi = 8'h03; cnt_lo = 8'h05;
        step();
        chk("R7 no irq", {irq, hi_flag}, 0);
        chk("R8 rdback after disarm", dl_rdback, 16'h0305);
    endtask

    task automatic t_cancel();
        cnt_hi = 8'h02; cnt_lo = 8'h10;
        write_dl(16'h0210);
        step();
        chk("R3 lo_armed", lo_armed, 1);
        step();
        chk("R5 irq", irq, 1);
        write_dl(16'h0500);
        chk("R10 irq dropped", {irq, hi_flag, lo_flag}, 0);
        step();
        chk("R10 reevaluated", {hi_armed, lo_armed}, 2'b10);
        chk("R8 rdback new", dl_rdback, 16'h0500);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_coarse_then_fine();
        t_same_edge();
        t_fine_direct();
        t_late_fallback();
        t_past();
        t_disarm();
        t_cancel();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule